// File: doc/BRIEF.md
# Multiply-Divide Occupancy and Hi/Lo Interlock

This block keeps the timing state of an integer multiply-divide unit and its result register pair, called hi and lo. The issue logic gives it one strobe for each instruction class that reaches the unit: 32-bit and 64-bit multiply, 32-bit and 64-bit divide, and a move into hi or into lo. In return the block says whether a new divide, a new multiply or a new move into hi/lo may issue this cycle, whether a read of hi or of lo would see a finished result, whether the divider is busy, and whether a wide multiply is holding off the next multiply. No arithmetic is done here. Everything is modelled with down-counters and a short shift register.

The divider cannot be pipelined. After a divide issues it spends three lead cycles before its iteration window starts, so one divide can issue while the window of the previous divide is still closing. All outputs depend only on registered state. The issue logic uses them in the same cycle as a gate.

Top module: `md_hilo_interlock`

## Requirements
- R1: During and directly after reset, `div_busy` and `mul_block` are 0, and `div_ok`, `mul_ok`, `mt_ok`, `hi_rdy` and `lo_rdy` are 1.
- R2: A divide issued in cycle t holds `div_busy` high from cycle t+4 through t+35 (32-bit) or t+67 (64-bit). The lead cycles t+1..t+3 are busy only if an earlier window covers them.
- R3: `div_ok` is 0 in the three cycles after a divide issues. It is also 0 while more than four busy cycles remain, counting the current one. A following divide may therefore issue in cycle t+32 (32-bit) or t+64 (64-bit), and its window never overlaps the earlier one.
- R4: A divide issued in cycle t holds `hi_rdy` and `lo_rdy` low from t+1 until they return high in cycle t+36 (32-bit) or t+68 (64-bit).
- R5: A 64-bit multiply issued in cycle t raises `mul_block` in cycle t+1. `mul_block` is high in no other cycle, and `mul_ok` is 0 while it is high.
- R6: A multiply issued in cycle t makes `lo_rdy` high again in cycle t+3. It makes `hi_rdy` high again in t+3 (32-bit) or t+4 (64-bit).
- R7: A move into hi (or lo) in cycle t holds `hi_rdy` (or `lo_rdy`) low until t+3. It holds `mul_ok` and `div_ok` low until t+4.
- R8: From one cycle after a divide issues until its result cycle (t+36 or t+68), `mt_ok` and `mul_ok` are 0. Another divide is not blocked by this rule.
- R9: When several producers are outstanding, each ready flag and hold-off returns only when the latest-finishing producer completes. A later producer never shortens a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_mul32 | input | 1 | 32-bit multiply issues this cycle |
| iss_mul64 | input | 1 | 64-bit multiply issues this cycle |
| iss_div32 | input | 1 | 32-bit divide issues this cycle |
| iss_div64 | input | 1 | 64-bit divide issues this cycle |
| iss_mthi | input | 1 | Move into hi issues this cycle |
| iss_mtlo | input | 1 | Move into lo issues this cycle |
| div_busy | output | 1 | Divider iteration window active |
| div_ok | output | 1 | A divide may issue this cycle |
| mul_block | output | 1 | Multiply held off by a preceding 64-bit multiply |
| mul_ok | output | 1 | A multiply may issue this cycle |
| mt_ok | output | 1 | A move into hi/lo may issue this cycle |
| hi_rdy | output | 1 | A read of hi would see its final value |
| lo_rdy | output | 1 | A read of lo would see its final value |

## Verification
Every result counts from the cycle its strobe is sampled. `mul_block` is due one edge later. The multiply and move readiness flags return three or four cycles later, and the divide results return 36 or 68 cycles later. The divider window opens four cycles after issue. The bench keeps a cycle model of these distances, written from the requirements. It updates the model at each rising edge with the strobes driven for that edge, and it compares all seven outputs at the following falling edge. Each comparison therefore lands exactly on the cycle a flag is due to change, including the cycle a second divide is first allowed to issue.

// File: rtl/md_pkg.sv
package md_pkg;
  // One slot of the divide lead pipeline: occupied flag and operand width.
  typedef struct packed {
    logic vld;
    logic wide;
  } div_tag_t;
endpackage

// File: rtl/lat_counter.sv
module lat_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);
  logic [W-1:0] cnt_q, cnt_d, dec;
  logic         upd;

  always_comb begin
    dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    cnt_d = dec;
    if (load_en && (load_val > dec)) cnt_d = load_val;
    upd   = load_en || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);

  // R9: with no new producer the wait only shrinks by one per cycle
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != '0) && !load_en) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("count did not step down");
endmodule

// File: rtl/div_window.sv
module div_window
  import md_pkg::*;
#(
  parameter int LEAD = 3,
  parameter int B32  = 32,
  parameter int B64  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wide,
  output logic busy,
  output logic can_issue
);
  localparam int BW = $clog2(B64 + 1);
  localparam logic [BW-1:0] K32   = BW'(B32);
  localparam logic [BW-1:0] K64   = BW'(B64);
  localparam logic [BW-1:0] KOVER = BW'(LEAD + 1);

  div_tag_t        lead_q [LEAD];
  div_tag_t        lead_d [LEAD];
  logic [BW-1:0]   busy_q, busy_d;
  logic            any_lead;

  always_comb begin
    lead_d[0].vld  = start;
    lead_d[0].wide = wide;
    for (int k = 1; k < LEAD; k++) lead_d[k] = lead_q[k-1];
    any_lead = 1'b0;
    for (int k = 0; k < LEAD; k++) any_lead = any_lead | lead_q[k].vld;
    if (lead_q[LEAD-1].vld)
      busy_d = lead_q[LEAD-1].wide ? K64 : K32;
    else
      busy_d = (busy_q == '0) ? '0 : busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int k = 0; k < LEAD; k++) lead_q[k] <= '0;
    end else begin
      busy_q <= busy_d;
      for (int k = 0; k < LEAD; k++) lead_q[k] <= lead_d[k];
    end
  end

  assign busy      = (busy_q != '0);
  assign can_issue = (busy_q <= KOVER) && !any_lead;

  // R2: the window opens the cycle after the last lead slot
  assert_window_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q[LEAD-1].vld |=> busy)
    else $error("divide window failed to open");

  // R3: no divide may be accepted while one is still in its lead cycles
  assert_no_issue_in_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_lead |-> !can_issue)
    else $error("divide allowed during lead");
endmodule

// File: rtl/md_hilo_interlock.sv
module md_hilo_interlock #(
  parameter int DIV32_BUSY   = 32,
  parameter int DIV64_BUSY   = 64,
  parameter int DIV_LEAD     = 3,
  parameter int MUL_LAT      = 3,
  parameter int MUL64_HI_LAT = 4,
  parameter int MT_READ_LAT  = 3,
  parameter int MT_SRC_LAT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iss_mul32,
  input  logic iss_mul64,
  input  logic iss_div32,
  input  logic iss_div64,
  input  logic iss_mthi,
  input  logic iss_mtlo,
  output logic div_busy,
  output logic div_ok,
  output logic mul_block,
  output logic mul_ok,
  output logic mt_ok,
  output logic hi_rdy,
  output logic lo_rdy
);
  localparam int DIV32_LAT = DIV_LEAD + 1 + DIV32_BUSY;
  localparam int DIV64_LAT = DIV_LEAD + 1 + DIV64_BUSY;
  localparam int CW        = $clog2(DIV64_LAT);
  localparam int NCNT      = 4;
  localparam int IX_HI = 0, IX_LO = 1, IX_PEND = 2, IX_SRC = 3;

  localparam logic [CW-1:0] K_DIV32 = CW'(DIV32_LAT - 1);
  localparam logic [CW-1:0] K_DIV64 = CW'(DIV64_LAT - 1);
  localparam logic [CW-1:0] K_MUL   = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] K_MULHI = CW'(MUL64_HI_LAT - 1);
  localparam logic [CW-1:0] K_MTRD  = CW'(MT_READ_LAT - 1);
  localparam logic [CW-1:0] K_MTSRC = CW'(MT_SRC_LAT - 1);

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic          ld_en  [NCNT];
  logic [CW-1:0] ld_val [NCNT];
  logic          cz     [NCNT];
  logic          any_div, any_mul, win_ok;
  logic          mblk_q, mblk_d;

  always_comb begin
    any_div = iss_div32 | iss_div64;
    any_mul = iss_mul32 | iss_mul64;
    for (int g = 0; g < NCNT; g++) ld_val[g] = '0;

    if (iss_mul32) ld_val[IX_HI] = mx(ld_val[IX_HI], K_MUL);
    if (iss_mul64) ld_val[IX_HI] = mx(ld_val[IX_HI], K_MULHI);
    if (iss_div32) ld_val[IX_HI] = mx(ld_val[IX_HI], K_DIV32);
    if (iss_div64) ld_val[IX_HI] = mx(ld_val[IX_HI], K_DIV64);
    if (iss_mthi)  ld_val[IX_HI] = mx(ld_val[IX_HI], K_MTRD);

    if (any_mul)   ld_val[IX_LO] = mx(ld_val[IX_LO], K_MUL);
    if (iss_div32) ld_val[IX_LO] = mx(ld_val[IX_LO], K_DIV32);
    if (iss_div64) ld_val[IX_LO] = mx(ld_val[IX_LO], K_DIV64);
    if (iss_mtlo)  ld_val[IX_LO] = mx(ld_val[IX_LO], K_MTRD);

    if (iss_div32) ld_val[IX_PEND] = mx(ld_val[IX_PEND], K_DIV32);
    if (iss_div64) ld_val[IX_PEND] = mx(ld_val[IX_PEND], K_DIV64);

    ld_val[IX_SRC] = K_MTSRC;

    ld_en[IX_HI]   = any_mul | any_div | iss_mthi;
    ld_en[IX_LO]   = any_mul | any_div | iss_mtlo;
    ld_en[IX_PEND] = any_div;
    ld_en[IX_SRC]  = iss_mthi | iss_mtlo;

    mblk_d = iss_mul64;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    lat_counter #(.W(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (ld_en[g]),
      .load_val (ld_val[g]),
      .is_zero  (cz[g])
    );
  end

  div_window #(
    .LEAD (DIV_LEAD),
    .B32  (DIV32_BUSY),
    .B64  (DIV64_BUSY)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (any_div),
    .wide      (iss_div64),
    .busy      (div_busy),
    .can_issue (win_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mblk_q <= 1'b0;
    else        mblk_q <= mblk_d;
  end

  assign mul_block = mblk_q;
  assign hi_rdy    = cz[IX_HI];
  assign lo_rdy    = cz[IX_LO];
  assign mt_ok     = cz[IX_PEND];
  assign div_ok    = win_ok & cz[IX_SRC];
  assign mul_ok    = ~mblk_q & cz[IX_PEND] & cz[IX_SRC];

  // R5: a wide multiply blocks exactly the following cycle
  assert_mul_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mul64 |=> (mul_block && !mul_ok))
    else $error("wide multiply did not block");
  assert_mul_block_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_mul64 |=> !mul_block)
    else $error("multiply block without wide multiply");

  // R8: hi/lo writers are held off once a divide is in flight
  assert_mt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_div32 || iss_div64) |=> (!mt_ok && !mul_ok))
    else $error("hi/lo write allowed behind divide");

  // R7: a move into hi makes hi unreadable for the next cycle
  assert_hi_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mthi |=> (!hi_rdy && !div_ok))
    else $error("hi readable right after move");

  // R6: any multiply makes lo unreadable for the next cycle
  assert_lo_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_mul32 || iss_mul64) |=> !lo_rdy)
    else $error("lo readable right after multiply");
endmodule

// File: tb/tb_md_hilo_interlock.sv
module tb_md_hilo_interlock;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_mul32, iss_mul64, iss_div32, iss_div64, iss_mthi, iss_mtlo;
  logic div_busy, div_ok, mul_block, mul_ok, mt_ok, hi_rdy, lo_rdy;

  int n_chk = 0;
  int n_fail = 0;

  // model state, written from the requirements
  int m_busy, m_pend, m_hi, m_lo, m_src;
  bit m_mblk;
  bit lv [3];
  bit lw [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  md_hilo_interlock dut (
    .clk(clk), .rst_n(rst_n),
    .iss_mul32(iss_mul32), .iss_mul64(iss_mul64),
    .iss_div32(iss_div32), .iss_div64(iss_div64),
    .iss_mthi(iss_mthi), .iss_mtlo(iss_mtlo),
    .div_busy(div_busy), .div_ok(div_ok), .mul_block(mul_block),
    .mul_ok(mul_ok), .mt_ok(mt_ok), .hi_rdy(hi_rdy), .lo_rdy(lo_rdy)
  );

  function automatic int dn(int x);
    return (x > 0) ? x - 1 : 0;
  endfunction

  function automatic int mxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit e_div_ok();
    return (m_busy <= 4) && !lv[0] && !lv[1] && !lv[2] && (m_src == 0);
  endfunction

  function automatic bit e_mul_ok();
    return !m_mblk && (m_pend == 0) && (m_src == 0);
  endfunction

  task automatic chk(string req, string sig, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", req, sig, $time, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "div_busy", div_busy, m_busy > 0);
    chk("R3", "div_ok", div_ok, e_div_ok());
    chk("R5", "mul_block", mul_block, m_mblk);
    chk("R7,R8", "mul_ok", mul_ok, e_mul_ok());
    chk("R8", "mt_ok", mt_ok, m_pend == 0);
    chk("R4,R6,R9", "hi_rdy", hi_rdy, m_hi == 0);
    chk("R4,R6,R9", "lo_rdy", lo_rdy, m_lo == 0);
  endtask

  task automatic model_reset();
    m_busy = 0; m_pend = 0; m_hi = 0; m_lo = 0; m_src = 0; m_mblk = 0;
    for (int k = 0; k < 3; k++) begin lv[k] = 0; lw[k] = 0; end
  endtask

  // one cycle: drive at the falling edge, update model at the rising edge,
  // compare at the next falling edge
  task automatic step(bit m32, bit m64, bit d32, bit d64, bit th, bit tl);
    int nhi, nlo, np;
    iss_mul32 = m32; iss_mul64 = m64; iss_div32 = d32;
    iss_div64 = d64; iss_mthi = th;  iss_mtlo = tl;
    @(posedge clk);
    m_busy = lv[2] ? (lw[2] ? 64 : 32) : dn(m_busy);
    lv[2] = lv[1]; lw[2] = lw[1];
    lv[1] = lv[0]; lw[1] = lw[0];
    lv[0] = d32 | d64; lw[0] = d64;
    nhi = dn(m_hi); nlo = dn(m_lo); np = dn(m_pend);
    if (m32) begin nhi = mxi(nhi, 2); nlo = mxi(nlo, 2); end
    if (m64) begin nhi = mxi(nhi, 3); nlo = mxi(nlo, 2); end
    if (d32) begin nhi = mxi(nhi, 35); nlo = mxi(nlo, 35); np = mxi(np, 35); end
    if (d64) begin nhi = mxi(nhi, 67); nlo = mxi(nlo, 67); np = mxi(np, 67); end
    if (th) nhi = mxi(nhi, 2);
    if (tl) nlo = mxi(nlo, 2);
    m_hi = nhi; m_lo = nlo; m_pend = np;
    m_src = (th | tl) ? 3 : dn(m_src);
    m_mblk = m64;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    iss_mul32 = 0; iss_mul64 = 0; iss_div32 = 0;
    iss_div64 = 0; iss_mthi = 0;  iss_mtlo = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "div_busy", div_busy, 1'b0);
    chk("R1", "mul_block", mul_block, 1'b0);
    chk("R1", "div_ok", div_ok, 1'b1);
    chk("R1", "mul_ok", mul_ok, 1'b1);
    chk("R1", "mt_ok", mt_ok, 1'b1);
    chk("R1", "hi_rdy", hi_rdy, 1'b1);
    chk("R1", "lo_rdy", lo_rdy, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2, R3: back-to-back 32-bit divides at the earliest legal cycle
    step(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0, 0);
    chk("R3", "div_ok at t+32", div_ok, 1'b1);
    step(0, 0, 1, 0, 0, 0);
    idle(70);

    // R2, R4: 64-bit divide, then a second one at t+64
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 63; i++) step(0, 0, 0, 0, 0, 0);
    chk("R3", "div_ok at t+64", div_ok, 1'b1);
    step(0, 0, 0, 1, 0, 0);
    // R8: hi/lo write attempts while divide is pending
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1);
    idle(75);

    // R5, R6: wide multiplies in a row and a narrow one
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    idle(6);

    // R7: moves into hi and lo, then a multiply behind them
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(2);
    step(0, 1, 0, 0, 0, 0);
    idle(6);

    // R9: short producer right after a long one
    step(0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    idle(40);

    // random mix
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom % 12;
      case (r)
        0: step(1, 0, 0, 0, 0, 0);
        1: step(0, 1, 0, 0, 0, 0);
        2: if (e_div_ok()) step(0, 0, 1, 0, 0, 0); else step(0, 0, 0, 0, 0, 0);
        3: if (e_div_ok()) step(0, 0, 0, 1, 0, 0); else step(0, 0, 0, 0, 0, 0);
        4: step(0, 0, 0, 0, 1, 0);
        5: step(0, 0, 0, 0, 0, 1);
        default: step(0, 0, 0, 0, 0, 0);
      endcase
    end
    idle(80);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule